// File: doc/BRIEF.md
# Mixture sort and background classifier

This block is the last stage of a per-pixel Gaussian-mixture background model. For each pixel it receives the three modes after their weight, mean and variance update, together with the outcome of the match search. The match search supplies a flag and the 1-based position of the matched mode in ascending weight order. The block also receives the background-mode count stored for the pixel in the previous frame and an 8-bit fractional threshold.

From these inputs it gives the current pixel a one-bit label: foreground or background. It also prepares the pixel's state for the next frame. The three modes are reordered into ascending weight order, with each mode's weight, mean and variance carried as one unit. A new background-mode count is then derived from the reordered weights. To find it, weights are added from the heaviest mode downward, and the count is the first point at which the running sum strictly exceeds the threshold.

All results are registered and appear one clock after a valid input. A new pixel can be accepted on every clock.

Top module: `mix_sort_classify`

## Requirements
- R1: When in_valid is 1 and in_match is 0, out_fg is 1 on the following clock.
- R2: When in_valid is 1 and in_match is 1, out_fg on the following clock is 0 exactly when in_idx + in_bg > 3. The sum is taken as plain integers without wraparound, for every in_idx in 0..3 and every in_bg in 0..15. Otherwise out_fg is 1.
- R3: Mode i occupies bits [i*W +: W] of the mode ports, with i = 0 the lightest. After a valid input, the registered weights satisfy slot0 <= slot1 <= slot2.
- R4: The outputs are a permutation of the input modes. Each mode's weight, mean and variance stay together. Modes with equal weights keep their input order, so the sort is stable.
- R5: out_bg is the smallest b in 1..3 such that the sum of the b heaviest sorted weights is strictly greater than in_thresh. The sum is an integer with at least 10 bits, so it never wraps.
- R6: When no such partial sum exceeds in_thresh, out_bg is 3.
- R7: The outputs reflect a valid input one clock later, and out_valid follows in_valid with one clock of delay. While in_valid is 0, the data outputs hold their values.
- R8: While rst_n is 0, out_valid is 0, out_fg is 1, and out_bg, out_wt, out_mean and out_var are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Pixel data present this cycle |
| in_match | input | 1 | A mode matched the pixel |
| in_idx | input | 2 | 1-based ascending-weight position of the matched mode |
| in_bg | input | 4 | Background-mode count from the previous frame |
| in_thresh | input | 8 | Background threshold, unsigned fraction |
| in_wt | input | 24 | Updated weights, three 8-bit fields |
| in_mean | input | 48 | Updated means, three 16-bit fields |
| in_var | input | 48 | Updated variances, three 16-bit fields |
| out_valid | output | 1 | Registered results valid |
| out_fg | output | 1 | 1 = foreground, 0 = background |
| out_wt | output | 24 | Weights in ascending order |
| out_mean | output | 48 | Means following their weights |
| out_var | output | 48 | Variances following their weights |
| out_bg | output | 4 | New background-mode count |

## Verification
A fault in the comparator network appears in the first registered result, one clock after the input. It shows up as an out-of-order weight slot, or as a mean or variance attached to the wrong weight, and sweeps with tied weights expose a lost tie order. A fault in the running sum appears in out_bg at that same cycle, and the threshold values placed next to partial sums make an error on the strict comparison visible. Faults in the label path show in out_fg only for particular combinations of index and stored count. For that reason every combination of flag, index and count is applied.

// File: rtl/mix_pkg.sv
package mix_pkg;
   localparam int NET_MODES = 3;
   typedef enum logic {
      LBL_BG = 1'b0,
      LBL_FG = 1'b1
   } label_e;
endpackage

// File: rtl/mix_label.sv
module mix_label #(
   parameter int NMODE = 3,
   parameter int IW    = 2,
   parameter int BW    = 4
) (
   input  logic          matched,
   input  logic [IW-1:0] idx,
   input  logic [BW-1:0] bg_prev,
   output logic          fg
);
   import mix_pkg::*;
   localparam int SW = ((BW > IW) ? BW : IW) + 1;

   logic [SW-1:0] rank_sum;

   // matched mode is background when it sits inside the top bg_prev slots
   always_comb begin
      rank_sum = SW'(idx) + SW'(bg_prev);
      if (!matched)
         fg = LBL_FG;
      else if (rank_sum > SW'(NMODE))
         fg = LBL_BG;
      else
         fg = LBL_FG;
   end
endmodule

// File: rtl/mix_sort3.sv
module mix_sort3 #(
   parameter int NMODE = 3,
   parameter int MW    = 40,
   parameter int WW    = 8
) (
   input  logic [NMODE*MW-1:0] d,
   output logic [NMODE*MW-1:0] q
);
   import mix_pkg::*;

   generate
      if (NMODE != NET_MODES) begin : g_bad_count
         $error("mix_sort3: network is built for exactly three modes");
      end
      if (WW > MW) begin : g_bad_key
         $error("mix_sort3: key wider than mode word");
      end
   endgenerate

   logic [MW-1:0] v [NMODE];
   logic [MW-1:0] tmp;

   // pairs (0,1), (1,2), (0,1); strict compare keeps ties in place
   always_comb begin
      tmp = '0;
      for (int i = 0; i < NMODE; i++) v[i] = d[i*MW +: MW];
      for (int s = 0; s < 3; s++) begin
         if (v[(s == 1) ? 1 : 0][MW-1 -: WW] > v[(s == 1) ? 2 : 1][MW-1 -: WW]) begin
            tmp = v[(s == 1) ? 1 : 0];
            v[(s == 1) ? 1 : 0] = v[(s == 1) ? 2 : 1];
            v[(s == 1) ? 2 : 1] = tmp;
         end
      end
      for (int i = 0; i < NMODE; i++) q[i*MW +: MW] = v[i];
   end
endmodule

// File: rtl/mix_bgcount.sv
module mix_bgcount #(
   parameter int NMODE = 3,
   parameter int WW    = 8,
   parameter int BW    = 4
) (
   input  logic [NMODE*WW-1:0] wt_sorted,
   input  logic [WW-1:0]       thresh,
   output logic [BW-1:0]       bg
);
   localparam int SW = WW + $clog2(NMODE) + 1;

   generate
      if (SW < 10) begin : g_narrow_sum
         $error("mix_bgcount: running sum narrower than 10 bits");
      end
      if ((1 << BW) <= NMODE) begin : g_narrow_bg
         $error("mix_bgcount: count field cannot hold NMODE");
      end
   endgenerate

   logic [SW-1:0] acc;
   logic          found;

   always_comb begin
      acc   = '0;
      found = 1'b0;
      bg    = BW'(NMODE);
      for (int k = 0; k < NMODE; k++) begin
         acc = acc + SW'(wt_sorted[(NMODE-1-k)*WW +: WW]);
         if (!found && (acc > SW'(thresh))) begin
            bg    = BW'(k + 1);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/mix_sort_classify.sv
module mix_sort_classify #(
   parameter int NMODE  = 3,
   parameter int W_WT   = 8,
   parameter int W_MEAN = 16,
   parameter int W_VAR  = 16,
   parameter int W_BG   = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic                        in_match,
   input  logic [$clog2(NMODE+1)-1:0]  in_idx,
   input  logic [W_BG-1:0]             in_bg,
   input  logic [W_WT-1:0]             in_thresh,
   input  logic [NMODE*W_WT-1:0]       in_wt,
   input  logic [NMODE*W_MEAN-1:0]     in_mean,
   input  logic [NMODE*W_VAR-1:0]      in_var,
   output logic                        out_valid,
   output logic                        out_fg,
   output logic [NMODE*W_WT-1:0]       out_wt,
   output logic [NMODE*W_MEAN-1:0]     out_mean,
   output logic [NMODE*W_VAR-1:0]      out_var,
   output logic [W_BG-1:0]             out_bg
);
   import mix_pkg::*;
   localparam int IW  = $clog2(NMODE+1);
   localparam int MW  = W_WT + W_MEAN + W_VAR;
   localparam int TSW = W_WT + $clog2(NMODE) + 1;

   generate
      if (NMODE != NET_MODES) begin : g_bad_modes
         $error("mix_sort_classify: NMODE must be 3");
      end
      if (W_WT < 2 || W_MEAN < 1 || W_VAR < 1) begin : g_bad_width
         $error("mix_sort_classify: field widths too small");
      end
   endgenerate

   logic [NMODE*MW-1:0]   word_in, word_srt;
   logic [NMODE*W_WT-1:0] wt_n;
   logic [NMODE*W_MEAN-1:0] mean_n;
   logic [NMODE*W_VAR-1:0] var_n;
   logic                  fg_n;
   logic [W_BG-1:0]       bg_n;

   genvar gi;
   generate
      for (gi = 0; gi < NMODE; gi++) begin : g_mode
         assign word_in[gi*MW +: MW] = {in_wt[gi*W_WT +: W_WT],
                                        in_mean[gi*W_MEAN +: W_MEAN],
                                        in_var[gi*W_VAR +: W_VAR]};
         assign wt_n[gi*W_WT +: W_WT]       = word_srt[gi*MW + W_MEAN + W_VAR +: W_WT];
         assign mean_n[gi*W_MEAN +: W_MEAN] = word_srt[gi*MW + W_VAR +: W_MEAN];
         assign var_n[gi*W_VAR +: W_VAR]    = word_srt[gi*MW +: W_VAR];
      end
   endgenerate

   mix_label #(.NMODE(NMODE), .IW(IW), .BW(W_BG)) u_label (
      .matched(in_match), .idx(in_idx), .bg_prev(in_bg), .fg(fg_n));

   mix_sort3 #(.NMODE(NMODE), .MW(MW), .WW(W_WT)) u_sort (
      .d(word_in), .q(word_srt));

   mix_bgcount #(.NMODE(NMODE), .WW(W_WT), .BW(W_BG)) u_bgc (
      .wt_sorted(wt_n), .thresh(in_thresh), .bg(bg_n));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_fg    <= LBL_FG;
         out_wt    <= '0;
         out_mean  <= '0;
         out_var   <= '0;
         out_bg    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_fg   <= fg_n;
            out_wt   <= wt_n;
            out_mean <= mean_n;
            out_var  <= var_n;
            out_bg   <= bg_n;
         end
      end
   end

   logic [TSW-1:0] in_wsum, out_wsum;
   always_comb begin
      in_wsum  = '0;
      out_wsum = '0;
      for (int i = 0; i < NMODE; i++) begin
         in_wsum  = in_wsum  + TSW'(in_wt[i*W_WT +: W_WT]);
         out_wsum = out_wsum + TSW'(out_wt[i*W_WT +: W_WT]);
      end
   end

   assert_nomatch_fg_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_match) |=> out_fg);

   assert_top_slots_bg_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_match && ((32'(in_idx) + 32'(in_bg)) > NMODE)) |=> !out_fg);

   assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_wt[0 +: W_WT] <= out_wt[W_WT +: W_WT]) &&
                     (out_wt[W_WT +: W_WT] <= out_wt[2*W_WT +: W_WT])));

   assert_weight_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_wsum == $past(in_wsum)));

   assert_bg_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ((out_bg >= 1) && (32'(out_bg) <= NMODE)));

   assert_valid_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_bg) && $stable(out_wt)));
endmodule

// File: tb/mix_sort_classify_test.sv
module mix_sort_classify_test;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, in_valid, in_match;
   logic [1:0]  in_idx;
   logic [3:0]  in_bg;
   logic [7:0]  in_thresh;
   logic [23:0] in_wt;
   logic [47:0] in_mean, in_var;
   logic        out_valid, out_fg;
   logic [23:0] out_wt;
   logic [47:0] out_mean, out_var;
   logic [3:0]  out_bg;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   mix_sort_classify uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_match(in_match),
      .in_idx(in_idx), .in_bg(in_bg), .in_thresh(in_thresh), .in_wt(in_wt),
      .in_mean(in_mean), .in_var(in_var), .out_valid(out_valid), .out_fg(out_fg),
      .out_wt(out_wt), .out_mean(out_mean), .out_var(out_var), .out_bg(out_bg));

   function automatic logic [15:0] mean_of(int tag, int i);
      return 16'((tag * 3 + i + 1) & 16'hFFFF);
   endfunction

   task automatic apply(input bit m, input int r, input int b, input int t,
                        input int w0, input int w1, input int w2, input int tag);
      int w[3];
      int ord[3];
      int acc, eb, tmp;
      bit found;
      bit efg;
      w[0] = w0; w[1] = w1; w[2] = w2;
      @(negedge clk);
      in_valid  = 1'b1;
      in_match  = m;
      in_idx    = r[1:0];
      in_bg     = b[3:0];
      in_thresh = t[7:0];
      in_wt     = {w2[7:0], w1[7:0], w0[7:0]};
      in_mean   = {mean_of(tag, 2), mean_of(tag, 1), mean_of(tag, 0)};
      in_var    = ~{mean_of(tag, 2), mean_of(tag, 1), mean_of(tag, 0)};
      @(negedge clk);
      vectors++;
      // expected: stable ascending order
      for (int i = 0; i < 3; i++) ord[i] = i;
      for (int p = 0; p < 2; p++)
         for (int j = 0; j < 2; j++)
            if (w[ord[j]] > w[ord[j+1]]) begin
               tmp = ord[j]; ord[j] = ord[j+1]; ord[j+1] = tmp;
            end
      acc = 0; eb = 3; found = 1'b0;
      for (int k = 1; k <= 3; k++) begin
         acc += w[ord[3-k]];
         if (!found && acc > t) begin eb = k; found = 1'b1; end
      end
      efg = !m || !((r + b) > 3);
      if (!out_valid) begin
         errors++;
         $display("FAIL R7 out_valid got %0b exp 1", out_valid);
      end
      if (out_fg !== efg) begin
         errors++;
         $display("FAIL %s out_fg got %0b exp %0b (m=%0b r=%0d b=%0d)",
                  m ? "R2" : "R1", out_fg, efg, m, r, b);
      end
      for (int p = 0; p < 3; p++) begin
         if (out_wt[p*8 +: 8] !== 8'(w[ord[p]])) begin
            errors++;
            $display("FAIL R3 slot %0d weight got %0d exp %0d", p, out_wt[p*8 +: 8], w[ord[p]]);
         end
         if (out_mean[p*16 +: 16] !== mean_of(tag, ord[p]) ||
             out_var[p*16 +: 16] !== ~mean_of(tag, ord[p])) begin
            errors++;
            $display("FAIL R4 slot %0d mean/var got %h/%h exp %h/%h", p,
                     out_mean[p*16 +: 16], out_var[p*16 +: 16],
                     mean_of(tag, ord[p]), ~mean_of(tag, ord[p]));
         end
      end
      if (out_bg !== 4'(eb)) begin
         errors++;
         $display("FAIL %s out_bg got %0d exp %0d (t=%0d w=%0d,%0d,%0d)",
                  found ? "R5" : "R6", out_bg, eb, t, w0, w1, w2);
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      int ws[6];
      int ts[7];
      int tag;
      ws = '{0, 1, 64, 128, 192, 255};
      ts = '{0, 63, 64, 128, 191, 254, 255};
      rst_n = 1'b0; in_valid = 1'b0; in_match = 1'b0; in_idx = '0; in_bg = '0;
      in_thresh = '0; in_wt = '0; in_mean = '0; in_var = '0;
      repeat (3) @(negedge clk);
      vectors++;
      if (out_valid !== 1'b0 || out_fg !== 1'b1 || out_bg !== 4'd0 ||
          out_wt !== '0 || out_mean !== '0 || out_var !== '0) begin
         errors++;
         $display("FAIL R8 reset state got v=%0b fg=%0b bg=%0d exp v=0 fg=1 bg=0",
                  out_valid, out_fg, out_bg);
      end
      rst_n = 1'b1;
      tag = 0;
      // R1 R2: every flag, index and stored count
      for (int m = 0; m < 2; m++)
         for (int r = 0; r < 4; r++)
            for (int b = 0; b < 16; b++) begin
               apply(m[0], r, b, 128, 10, 40, 200, tag);
               tag++;
            end
      // R3 R4 R5 R6: weight triples with ties, against thresholds near partial sums
      for (int a = 0; a < 6; a++)
         for (int b = 0; b < 6; b++)
            for (int c = 0; c < 6; c++)
               for (int ti = 0; ti < 7; ti++) begin
                  apply(tag[0], (tag >> 1) % 4, (tag >> 3) % 5, ts[ti],
                        ws[a], ws[b], ws[c], tag);
                  tag++;
               end
      // R5 strict boundary: heaviest weight equal to the threshold
      apply(1'b1, 3, 1, 100, 5, 7, 100, tag); tag++;
      apply(1'b1, 3, 1, 99, 5, 7, 100, tag); tag++;
      // R7: idle cycle drops out_valid and holds data
      @(negedge clk);
      in_valid = 1'b0;
      in_wt    = 24'hFFFFFF;
      in_thresh = 8'd0;
      @(negedge clk);
      vectors++;
      if (out_valid !== 1'b0 || out_bg !== 4'd1 || out_wt[23:16] !== 8'd100) begin
         errors++;
         $display("FAIL R7 idle got v=%0b bg=%0d top=%0d exp v=0 bg=1 top=100",
                  out_valid, out_bg, out_wt[23:16]);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule